// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block holds the time of day and the calendar date as packed BCD bytes, from hundredths of a second through a two-digit year, together with a day of the week and a week-of-year number. It moves forward by one hundredth on each pulse of a 100 Hz tick strobe, produced elsewhere. The carry runs through seconds, minutes, hours, days, months and years in the same clock cycle. The hour is stored in 24-hour form and shown in either 24-hour or 12-hour form, chosen by a configuration bit.

A sync input can pull the time into line with an outside event. It can round to the nearest second or to the nearest minute. It can also replace the internal tick with a mains-frequency reference, where every second rising edge counts as one hundredth. Software loads any field through a byte-wide write port. A set-lock input freezes all counting while a new time is written.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Hundredths count 00..99 and seconds and minutes count 00..59, all in BCD. A tick at 99 hundredths gives 00 and carries one second. A carry at 59 seconds gives 00 and carries one minute.
- R2: The stored hour counts 00..23. A carry out of minute 59 at hour 23 gives hour 00 and advances the date by one day.
- R3: With cfg_12h=1, the hour output and hour writes use 12-hour form. Bit 7 is set for PM (internal 12..23) and bits 6:0 hold BCD 12, 01..11. Internal 00 reads 0x12, internal 12 reads 0x92 and internal 13 reads 0x81.
- R4: The day of the month wraps to 01 after the month's last day. Months have 31 days, except 04, 06, 09 and 11, which have 30. Month 02 has 29 days when the year is divisible by 4 and 28 otherwise. Month 12 wraps to 01 and the year 99 wraps to 00.
- R5: The weekday runs 1..7, Monday=1, and steps once per day from 7 to 1.
- R6: The week number becomes 01 on every 1 January. On any other day it rises by one when the weekday goes from 7 to 1, and it holds at 53.
- R7: A write with wr_en=1 loads wr_data into the field chosen by wr_sel at the next edge. The codes are 0 hundredths, 1 seconds, 2 minutes, 3 hour, 4 weekday, 5 day, 6 month, 7 year and 8 week. A tick or sync event in the same cycle as a write is dropped.
- R8: While set_lock=1, ticks and sync edges change no field. Writes are still taken.
- R9: With sync_mode=01, a rising edge on sync_in clears the hundredths. If the hundredths were 50 or more, it also adds one second and lets that carry ripple upward.
- R10: With sync_mode=10, a rising edge clears the seconds and hundredths. If the seconds were 30 or more, it also adds one minute.
- R11: With sync_mode=11, tick_100hz is ignored. Counting from entry into the mode, every second rising edge of sync_in adds one hundredth.
- R12: Reset gives 00:00:00.00, weekday 1, day 01, month 01, year 00 and week 01.
- R13: With sync_mode=00, edges on sync_in have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100hz | input | 1 | One-cycle pulse per hundredth of a second |
| sync_in | input | 1 | External sync, acted on at its rising edge |
| sync_mode | input | 2 | 00 off, 01 nearest second, 10 nearest minute, 11 mains reference |
| set_lock | input | 1 | Freezes counting while high |
| cfg_12h | input | 1 | 1 selects 12-hour form for hour reads and writes |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 4 | Field code for the write |
| wr_data | input | 8 | BCD value to write |
| hund_o | output | 8 | Hundredths, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour, BCD in the selected form |
| wday_o | output | 8 | Weekday 1..7 |
| mday_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00..99, BCD |
| week_o | output | 8 | Week number 01..53, BCD |

## Verification
The hardest cases to reach from the ports are the calendar corners: leap days, the year wrap, the week number reset on 1 January and the hold at week 53. Counting to them by ticks alone would take millions of cycles. The bench instead loads 23:59:59.99 through the write port and gives a single tick, so each simulated day costs about ten cycles. This lets it walk two consecutive years day by day against an arithmetic calendar model. It also visits 28 February in all hundred years. The rounding modes are swept over every hundredths value and every seconds value, and the mains mode is checked edge by edge from entry into the mode.

// File: rtl/rtc_pkg.sv
// Shared types and BCD helpers for the calendar counter.
// Assumes every BCD byte handed to these helpers holds legal digits.
package rtc_pkg;

    typedef logic [7:0] bcd8_t;

    typedef enum logic [1:0] {
        SYNC_OFF = 2'b00,
        SYNC_SEC = 2'b01,
        SYNC_MIN = 2'b10,
        SYNC_REF = 2'b11
    } sync_mode_e;

    typedef enum logic [3:0] {
        F_HUND  = 4'd0,
        F_SEC   = 4'd1,
        F_MIN   = 4'd2,
        F_HOUR  = 4'd3,
        F_WDAY  = 4'd4,
        F_MDAY  = 4'd5,
        F_MONTH = 4'd6,
        F_YEAR  = 4'd7,
        F_WEEK  = 4'd8
    } field_e;

    // Next value of a two-digit BCD number (no wrap at the top).
    function automatic bcd8_t bcd_next(bcd8_t v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Divisible-by-four test done on the BCD digits directly.
    function automatic logic bcd_leap(bcd8_t yr);
        if (!yr[4])
            return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    endfunction

    // Last day of a month, BCD.
    function automatic bcd8_t month_last(bcd8_t mon, bcd8_t yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // 24-hour BCD to 12-hour BCD, bit 7 set for PM.
    function automatic bcd8_t hour_to_12(bcd8_t h);
        if (h == 8'h00)       return 8'h12;
        if (h < 8'h12)        return h;
        if (h == 8'h12)       return 8'h92;
        if (h[7:4] == 4'd1)   return {4'h8, h[3:0] - 4'd2};
        if (h[3:0] <= 4'd1)   return {4'h8, h[3:0] + 4'd8};
        return {4'h9, h[3:0] - 4'd2};
    endfunction

    // 12-hour BCD with PM in bit 7 back to 24-hour BCD.
    function automatic bcd8_t hour_from_12(bcd8_t d);
        bcd8_t h;
        h = {1'b0, d[6:0]};
        if (h == 8'h12)       return d[7] ? 8'h12 : 8'h00;
        if (!d[7])            return h;
        if (h[7:4] == 4'd1)   return {4'h2, h[3:0] + 4'd2};
        if (h[3:0] >= 4'd8)   return {4'h2, h[3:0] - 4'd8};
        return {4'h1, h[3:0] + 4'd2};
    endfunction

endpackage

// File: rtl/rtc_sync_ctrl.sv
// Turns the tick, the sync input and the mode into count events.
// Produces at most one of step_hund, round_sec and round_min per cycle.
// All three are suppressed while set_lock or wr_en is high.
// Assumes sync_in is already synchronous to clk.
module rtc_sync_ctrl #(
    parameter int REF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       sync_in,
    input  logic [1:0] mode,
    input  logic       lock,
    input  logic       wr_en,
    output logic       step_hund,
    output logic       round_sec,
    output logic       round_min
);
    import rtc_pkg::*;

    localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

    logic          sync_prev;
    logic [CW-1:0] ref_cnt;
    logic          sync_rise;
    logic          quiet;
    logic          ref_wrap;
    logic          ref_mode;
    logic          round_any;

    assign sync_rise = sync_in && !sync_prev;
    assign quiet     = !lock && !wr_en;
    assign ref_mode  = (mode == SYNC_REF);
    assign ref_wrap  = (ref_cnt == CW'(REF_DIV - 1));
    assign round_any = sync_rise && ((mode == SYNC_SEC) || (mode == SYNC_MIN));

    // Remember the previous sync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev <= 1'b0;
        else        sync_prev <= sync_in;
    end

    // Count reference edges; restart whenever the mode is left.
    always_ff @(posedge clk) begin
        if (!rst_n || !ref_mode) ref_cnt <= '0;
        else if (sync_rise)      ref_cnt <= ref_wrap ? '0 : ref_cnt + CW'(1);
    end

    // Decide which count event, if any, this cycle carries.
    always_comb begin
        if (ref_mode) step_hund = quiet && sync_rise && ref_wrap;
        else          step_hund = quiet && tick && !round_any;
        round_sec = quiet && sync_rise && (mode == SYNC_SEC);
        round_min = quiet && sync_rise && (mode == SYNC_MIN);
    end

endmodule

// File: rtl/rtc_time_chain.sv
// Time-of-day counters: hundredths, seconds, minutes, 24-hour hour.
// The carry ripples through all stages in one cycle. day_step is a
// same-cycle pulse for the date chain. Assumes written values are legal BCD.
module rtc_time_chain (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_hund,
    input  logic       round_sec,
    input  logic       round_min,
    input  logic       wr_en,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] hund,
    output logic [7:0] sec,
    output logic [7:0] minute,
    output logic [7:0] hr24,
    output logic       day_step
);
    import rtc_pkg::*;

    logic inc_sec;
    logic inc_min;
    logic inc_hr;

    // Carry chain including the rounding requests.
    always_comb begin
        inc_sec  = (step_hund && hund >= 8'h99) || (round_sec && hund >= 8'h50);
        inc_min  = (inc_sec && sec >= 8'h59) || (round_min && sec >= 8'h30);
        inc_hr   = inc_min && minute >= 8'h59;
        day_step = inc_hr && hr24 >= 8'h23;
    end

    // Hundredths register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             hund <= 8'h00;
        else if (wr_en && wr_sel == F_HUND)     hund <= wr_data;
        else if (round_sec || round_min)        hund <= 8'h00;
        else if (step_hund)                     hund <= (hund >= 8'h99) ? 8'h00 : bcd_next(hund);
    end

    // Seconds register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             sec <= 8'h00;
        else if (wr_en && wr_sel == F_SEC)      sec <= wr_data;
        else if (round_min)                     sec <= 8'h00;
        else if (inc_sec)                       sec <= (sec >= 8'h59) ? 8'h00 : bcd_next(sec);
    end

    // Minutes register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             minute <= 8'h00;
        else if (wr_en && wr_sel == F_MIN)      minute <= wr_data;
        else if (inc_min)                       minute <= (minute >= 8'h59) ? 8'h00 : bcd_next(minute);
    end

    // Hour register, always 24-hour form.
    always_ff @(posedge clk) begin
        if (!rst_n)                             hr24 <= 8'h00;
        else if (wr_en && wr_sel == F_HOUR)     hr24 <= wr_data;
        else if (inc_hr)                        hr24 <= (hr24 >= 8'h23) ? 8'h00 : bcd_next(hr24);
    end

endmodule

// File: rtl/rtc_date_chain.sv
// Date counters: weekday, day of month, month, year, week number.
// Advances on day_step. The week resets on 1 January, otherwise rises
// entering Monday and holds at WEEK_LAST. Assumes legal BCD writes.
module rtc_date_chain #(
    parameter logic [7:0] WEEK_LAST = 8'h53
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_step,
    input  logic       wr_en,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] wday,
    output logic [7:0] mday,
    output logic [7:0] month,
    output logic [7:0] year,
    output logic [7:0] week
);
    import rtc_pkg::*;

    logic inc_mon;
    logic inc_year;
    logic new_week;

    // Month and year carries and the Monday transition.
    always_comb begin
        inc_mon  = day_step && (mday >= month_last(month, year));
        inc_year = inc_mon && (month >= 8'h12);
        new_week = day_step && (wday >= 8'h07);
    end

    // Weekday register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             wday <= 8'h01;
        else if (wr_en && wr_sel == F_WDAY)     wday <= wr_data;
        else if (day_step)                      wday <= (wday >= 8'h07) ? 8'h01 : wday + 8'h01;
    end

    // Day-of-month register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             mday <= 8'h01;
        else if (wr_en && wr_sel == F_MDAY)     mday <= wr_data;
        else if (inc_mon)                       mday <= 8'h01;
        else if (day_step)                      mday <= bcd_next(mday);
    end

    // Month register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             month <= 8'h01;
        else if (wr_en && wr_sel == F_MONTH)    month <= wr_data;
        else if (inc_year)                      month <= 8'h01;
        else if (inc_mon)                       month <= bcd_next(month);
    end

    // Year register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             year <= 8'h00;
        else if (wr_en && wr_sel == F_YEAR)     year <= wr_data;
        else if (inc_year)                      year <= (year >= 8'h99) ? 8'h00 : bcd_next(year);
    end

    // Week-number register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             week <= 8'h01;
        else if (wr_en && wr_sel == F_WEEK)     week <= wr_data;
        else if (inc_year)                      week <= 8'h01;
        else if (new_week && week < WEEK_LAST)  week <= bcd_next(week);
    end

endmodule

// File: rtl/rtc_bcd_calendar.sv
// Top of the BCD real-time calendar counter.
// Joins event control, time chain and date chain, and converts the hour
// between 24-hour storage and the 12-hour form on reads and writes.
// Assumes tick_100hz and sync_in are synchronous to clk.
module rtc_bcd_calendar #(
    parameter int         REF_DIV   = 2,
    parameter logic [7:0] WEEK_LAST = 8'h53
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_100hz,
    input  logic       sync_in,
    input  logic [1:0] sync_mode,
    input  logic       set_lock,
    input  logic       cfg_12h,
    input  logic       wr_en,
    input  logic [3:0] wr_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] hund_o,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [7:0] week_o
);
    import rtc_pkg::*;

    logic       step_hund;
    logic       round_sec;
    logic       round_min;
    logic       day_step;
    logic [7:0] hr24;
    logic [7:0] wdata_int;

    // Hour writes in 12-hour form are converted before storage.
    always_comb begin
        if (cfg_12h && wr_sel == F_HOUR) wdata_int = hour_from_12(wr_data);
        else                             wdata_int = wr_data;
    end

    // Hour reads follow the selected form.
    assign hour_o = cfg_12h ? hour_to_12(hr24) : hr24;

    rtc_sync_ctrl #(.REF_DIV(REF_DIV)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_100hz),
        .sync_in   (sync_in),
        .mode      (sync_mode),
        .lock      (set_lock),
        .wr_en     (wr_en),
        .step_hund (step_hund),
        .round_sec (round_sec),
        .round_min (round_min)
    );

    rtc_time_chain u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_hund (step_hund),
        .round_sec (round_sec),
        .round_min (round_min),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wdata_int),
        .hund      (hund_o),
        .sec       (sec_o),
        .minute    (min_o),
        .hr24      (hr24),
        .day_step  (day_step)
    );

    rtc_date_chain #(.WEEK_LAST(WEEK_LAST)) u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_step  (day_step),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wdata_int),
        .wday      (wday_o),
        .mday      (mday_o),
        .month     (month_o),
        .year      (year_o),
        .week      (week_o)
    );

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
// Property checker for the calendar counter, attached by bind.
// Observes only the top-level ports, plus its own copy of the sync level.
module rtc_bcd_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_100hz,
    input logic       sync_in,
    input logic [1:0] sync_mode,
    input logic       set_lock,
    input logic       cfg_12h,
    input logic       wr_en,
    input logic [7:0] hund_o,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] wday_o,
    input logic [7:0] mday_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic [7:0] week_o
);
    logic sync_seen;

    // Track the sync level to see rising edges independently.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_seen <= 1'b0;
        else        sync_seen <= sync_in;
    end

    // R1
    hund_digits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hund_o[3:0] <= 4'd9 && hund_o[7:4] <= 4'd9);

    // R1
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_100hz && !set_lock && !wr_en && sync_mode == 2'b00 &&
         hund_o == 8'h99 && sec_o == 8'h59) |=> (sec_o == 8'h00 && hund_o == 8'h00));

    // R3
    hour12_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_12h |-> (hour_o[6:0] != 7'h00 && hour_o[6:0] <= 7'h12));

    // R5
    wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wday_o >= 8'h01 && wday_o <= 8'h07);

    // R6
    week_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        week_o >= 8'h01 && week_o <= 8'h53);

    // R8
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_lock && !wr_en) |=> ($stable(hund_o) && $stable(sec_o) && $stable(min_o) &&
                                  $stable(mday_o) && $stable(month_o) && $stable(year_o) &&
                                  $stable(wday_o) && $stable(week_o)));

    // R9
    round_sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode == 2'b01 && sync_in && !sync_seen && !set_lock && !wr_en) |=> hund_o == 8'h00);

    // R11
    ref_tick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode == 2'b11 && tick_100hz && !wr_en && !(sync_in && !sync_seen)) |=> $stable(hund_o));

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_100hz (tick_100hz),
    .sync_in    (sync_in),
    .sync_mode  (sync_mode),
    .set_lock   (set_lock),
    .cfg_12h    (cfg_12h),
    .wr_en      (wr_en),
    .hund_o     (hund_o),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o),
    .wday_o     (wday_o),
    .mday_o     (mday_o),
    .month_o    (month_o),
    .year_o     (year_o),
    .week_o     (week_o)
);

// File: tb/sim_rtc_bcd_calendar.sv
// Self-checking bench: sweeps counting, calendar days, hour forms and sync modes.
module sim_rtc_bcd_calendar;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic       sync_in = 1'b0;
    logic [1:0] sync_mode = 2'b00;
    logic       set_lock = 1'b0;
    logic       cfg_12h = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_sel = 4'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] hund_o, sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o, week_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rtc_bcd_calendar u0 (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .sync_in(sync_in),
        .sync_mode(sync_mode), .set_lock(set_lock), .cfg_12h(cfg_12h),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .hund_o(hund_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .wday_o(wday_o), .mday_o(mday_o), .month_o(month_o), .year_o(year_o),
        .week_o(week_o)
    );

    function automatic logic [7:0] bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] exp12(int h);
        int h12;
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return {(h >= 12) ? 1'b1 : 1'b0, bcd(h12)[6:0]};
    endfunction

    function automatic int mlen(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk);
        tick_100hz = 1'b1;
        @(negedge clk);
        tick_100hz = 1'b0;
    endtask

    task automatic sync1();
        @(negedge clk);
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    task automatic load_eod();
        wr(4'd3, 8'h23); wr(4'd2, 8'h59); wr(4'd1, 8'h59); wr(4'd0, 8'h99);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int y, m, d, wd, wk;
        logic [7:0] s_keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        check("R12 hund", hund_o, 8'h00);  check("R12 sec", sec_o, 8'h00);
        check("R12 min", min_o, 8'h00);    check("R12 hour", hour_o, 8'h00);
        check("R12 wday", wday_o, 8'h01);  check("R12 mday", mday_o, 8'h01);
        check("R12 month", month_o, 8'h01); check("R12 year", year_o, 8'h00);
        check("R12 week", week_o, 8'h01);

        // R1 two minutes of ticks
        for (int i = 1; i <= 12000; i++) begin
            tick1();
            check("R1 hund", hund_o, bcd(i % 100));
            check("R1 sec", sec_o, bcd((i / 100) % 60));
            check("R1 min", min_o, bcd(i / 6000));
        end

        // R2 / R3 hour sweep in 24-hour writes, 12-hour view, rollover
        for (int h = 0; h < 24; h++) begin
            wr(4'd3, bcd(h)); wr(4'd2, 8'h59); wr(4'd1, 8'h59); wr(4'd0, 8'h99);
            check("R2 hour24", hour_o, bcd(h));
            @(negedge clk); cfg_12h = 1'b1; #1;
            check("R3 hour12 view", hour_o, exp12(h));
            @(negedge clk); cfg_12h = 1'b0;
            tick1();
            check("R2 hour step", hour_o, bcd((h + 1) % 24));
            check("R2 min wrap", min_o, 8'h00);
        end

        // R3 writes in 12-hour form
        for (int h = 0; h < 24; h++) begin
            @(negedge clk); cfg_12h = 1'b1;
            wr(4'd3, exp12(h));
            check("R3 hour12 write", hour_o, exp12(h));
            @(negedge clk); cfg_12h = 1'b0; #1;
            check("R3 hour12 stored", hour_o, bcd(h));
        end

        // R4 R5 R6 day-by-day sweep of years 23 and 24
        y = 23; m = 1; d = 1; wd = 7; wk = 1;
        wr(4'd7, bcd(y)); wr(4'd6, bcd(m)); wr(4'd5, bcd(d));
        wr(4'd4, bcd(wd)); wr(4'd8, bcd(wk));
        for (int n = 0; n < 731; n++) begin
            load_eod();
            tick1();
            wd = (wd == 7) ? 1 : wd + 1;
            if (d == mlen(m, y)) begin
                d = 1;
                if (m == 12) begin m = 1; y = (y + 1) % 100; end
                else m++;
            end else d++;
            if (d == 1 && m == 1) wk = 1;
            else if (wd == 1 && wk < 53) wk++;
            check("R4 mday", mday_o, bcd(d));  check("R4 month", month_o, bcd(m));
            check("R4 year", year_o, bcd(y));  check("R5 wday", wday_o, bcd(wd));
            check("R6 week", week_o, bcd(wk)); check("R2 midnight", hour_o, 8'h00);
        end

        // R4 leap rule over all hundred years
        for (int yy = 0; yy < 100; yy++) begin
            wr(4'd7, bcd(yy)); wr(4'd6, 8'h02); wr(4'd5, 8'h28);
            load_eod();
            tick1();
            check("R4 feb day", mday_o, (yy % 4 == 0) ? 8'h29 : 8'h01);
            check("R4 feb month", month_o, (yy % 4 == 0) ? 8'h02 : 8'h03);
        end

        // R4 R6 year 99 wraps, week forced to 01
        wr(4'd7, 8'h99); wr(4'd6, 8'h12); wr(4'd5, 8'h31); wr(4'd4, 8'h03); wr(4'd8, 8'h53);
        load_eod(); tick1();
        check("R4 year wrap", year_o, 8'h00); check("R4 month wrap", month_o, 8'h01);
        check("R6 jan1 week", week_o, 8'h01); check("R5 wday", wday_o, 8'h04);

        // R6 week holds at 53 on a Monday that is not 1 January
        wr(4'd7, 8'h25); wr(4'd6, 8'h12); wr(4'd5, 8'h29); wr(4'd4, 8'h07); wr(4'd8, 8'h53);
        load_eod(); tick1();
        check("R6 week hold", week_o, 8'h53); check("R5 wday wrap", wday_o, 8'h01);

        // R13 sync ignored when off
        wr(4'd0, 8'h40); sync1();
        check("R13 sync off", hund_o, 8'h40);

        // R9 nearest second over every hundredths value
        @(negedge clk); sync_mode = 2'b01;
        for (int v = 0; v < 100; v++) begin
            wr(4'd1, 8'h10); wr(4'd2, 8'h20); wr(4'd0, bcd(v));
            sync1();
            check("R9 hund", hund_o, 8'h00);
            check("R9 sec", sec_o, (v >= 50) ? 8'h11 : 8'h10);
        end
        wr(4'd1, 8'h59); wr(4'd2, 8'h20); wr(4'd0, 8'h75); sync1();
        check("R9 carry sec", sec_o, 8'h00); check("R9 carry min", min_o, 8'h21);

        // R10 nearest minute over every seconds value
        @(negedge clk); sync_mode = 2'b10;
        for (int s = 0; s < 60; s++) begin
            wr(4'd2, 8'h05); wr(4'd1, bcd(s)); wr(4'd0, 8'h37);
            sync1();
            check("R10 sec", sec_o, 8'h00); check("R10 hund", hund_o, 8'h00);
            check("R10 min", min_o, (s >= 30) ? 8'h06 : 8'h05);
        end

        // R11 mains reference mode
        wr(4'd0, 8'h00);
        @(negedge clk); sync_mode = 2'b11;
        repeat (5) tick1();
        check("R11 tick ignored", hund_o, 8'h00);
        for (int k = 1; k <= 40; k++) begin
            sync1();
            check("R11 edge count", hund_o, bcd(k / 2));
        end

        // R8 lock: writes taken, ticks and sync ignored
        @(negedge clk); sync_mode = 2'b01; set_lock = 1'b1;
        wr(4'd0, 8'h33);
        check("R8 write while locked", hund_o, 8'h33);
        s_keep = sec_o;
        repeat (3) tick1();
        sync1();
        check("R8 hund frozen", hund_o, 8'h33); check("R8 sec frozen", sec_o, s_keep);
        @(negedge clk); set_lock = 1'b0;
        tick1();
        check("R8 resumes", hund_o, 8'h34);

        // R7 write in the same cycle as a tick drops the tick
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 4'd0; wr_data = 8'h20; tick_100hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_100hz = 1'b0;
        check("R7 write beats tick", hund_o, 8'h20);
        check("R7 other field untouched", sec_o, s_keep);

        done = 1'b1;
        finish_run();
    end

endmodule